// File: doc/BRIEF.md
# Serializer with Two-Tap Pre-Emphasis Encoder

This block converts a parallel transmit word into a serial bit stream and turns that stream into the select pattern for a voltage-mode output driver built from binary-weighted segments. A word is taken in once per word period. A binary tree of 2:1 selectors then picks its bits out one per bit time, least significant bit first. The tree levels step at rates of 1/2, 1/4, 1/8 and so on of the bit rate. All of them come from one counter that runs on the bit clock.

The encoder keeps the current serial bit and a copy delayed by one bit time. Each driver segment pulls either up or down, never neither. A segment whose coefficient bit is set follows the inverted delayed bit, and every other segment follows the current bit. The whole driver therefore always presents the same total conductance, while the split between up and down sets one of 2^SEG_N output levels. The analog driver and its calibration loops are outside this block.

Top module: `ser_emph_top`

## Requirements
- R1: `word_stb_o` is high in exactly one cycle of every WORD_W cycles. The first time is WORD_W-1 cycles after reset is released. The value on `data_i` in that cycle is the word that is captured at the following rising edge.
- R2: Bit k of a captured word (bit 0 first) appears on `ser_o` starting at the (k+1)-th rising edge after the capture edge, one bit per cycle, with no gap between words.
- R3: A change on `data_i` in any cycle where `word_stb_o` is low has no effect on `ser_o` or `seg_up_o`.
- R4: `ser_dly_o` equals the value `ser_o` had one cycle earlier.
- R5: Bit i of `seg_up_o` drives segment i, whose weight is 2^i; 1 means pull-up and 0 means pull-down. After each edge, segment i equals the inverse of `ser_dly_o` when bit i of the coefficient sampled at that edge was 1, and equals `ser_o` when it was 0.
- R6: With a coefficient of zero, every bit of `seg_up_o` equals `ser_o`.
- R7: `coef_i` is sampled at every rising edge, so a new coefficient governs the segment pattern from the next edge on, even in the middle of a word.
- R8: While the synchronous active-high `rst_i` is sampled high, `seg_up_o` becomes all zeros (all pull-down) and `ser_o`, `ser_dly_o` and `word_stb_o` become 0, whatever the coefficient is. This also applies when reset is asserted in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| data_i | input | WORD_W | Parallel transmit word |
| coef_i | input | SEG_N | Pre-emphasis coefficient, bit i selects segment i |
| word_stb_o | output | 1 | High in the cycle where `data_i` is captured |
| ser_o | output | 1 | Current serial bit |
| ser_dly_o | output | 1 | Serial bit delayed by one bit time |
| seg_up_o | output | SEG_N | Segment selects, 1 = pull-up |

## Verification
`word_stb_o` comes from the counter through logic only, so it is compared in the same cycle as the counter state. A captured word reaches `ser_o` through the hold register and then the output flop: bit k is due k+1 edges after the capture edge. The segment pattern and the delayed tap are registered at the same edge as `ser_o`, and the coefficient applied is the one present just before that edge. The bench drives inputs on the falling edge and advances a reference model by one step per rising edge. It then compares every output on the following falling edge, so each comparison waits for exactly the register stages in its path.

// File: rtl/ser_emph_pkg.sv
package ser_emph_pkg;

   // number of selector levels for a power-of-two word width
   function automatic int tree_levels(input int width);
      int n;
      n = 0;
      while ((1 << n) < width) n++;
      return n;
   endfunction

   function automatic bit is_pow2(input int width);
      return (width >= 2) && ((width & (width - 1)) == 0);
   endfunction

   typedef enum logic {
      DRV_DOWN = 1'b0,
      DRV_UP   = 1'b1
   } drv_dir_e;

endpackage

// File: rtl/ser_rate_div.sv
module ser_rate_div #(
   parameter int WORD_W = 16,
   localparam int LVL   = ser_emph_pkg::tree_levels(WORD_W)
) (
   input  logic           clk_i,
   input  logic           rst_i,
   output logic [LVL-1:0] phase_o,
   output logic           stb_o
);

   logic [LVL-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_q + 1'b1;
   end

   assign phase_o = cnt_q;
   assign stb_o   = (cnt_q == LVL'(WORD_W - 1));

   // R1
   stb_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      stb_o |=> !stb_o);

   // R1
   phase_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (cnt_q == LVL'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/ser_mux_tree.sv
module ser_mux_tree #(
   parameter int WORD_W = 16,
   localparam int LVL   = ser_emph_pkg::tree_levels(WORD_W)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [LVL-1:0]    phase_i,
   output logic              bit_o
);

   logic [WORD_W-1:0] held_q;
   logic [WORD_W-1:0] stage [0:LVL];

   always_ff @(posedge clk_i) begin
      if (rst_i)       held_q <= '0;
      else if (load_i) held_q <= word_i;
   end

   assign stage[0] = held_q;

   // level lv runs at 1/2^(LVL-lv) of the bit rate: it is steered by phase bit LVL-1-lv
   for (genvar lv = 0; lv < LVL; lv++) begin : g_lvl
      localparam int HALF = WORD_W >> (lv + 1);
      for (genvar j = 0; j < HALF; j++) begin : g_sel
         assign stage[lv+1][j] = phase_i[LVL-1-lv] ? stage[lv][j+HALF] : stage[lv][j];
      end
      assign stage[lv+1][WORD_W-1:HALF] = '0;
   end

   assign bit_o = stage[LVL][0];

   // R3
   held_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_i |=> $stable(held_q));

endmodule

// File: rtl/ser_emph_enc.sv
module ser_emph_enc #(
   parameter int SEG_N = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             bit_i,
   input  logic [SEG_N-1:0] coef_i,
   output logic             cur_o,
   output logic             dly_o,
   output logic [SEG_N-1:0] seg_o
);
   import ser_emph_pkg::*;

   logic             cur_q, dly_q;
   logic [SEG_N-1:0] seg_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cur_q <= 1'b0;
         dly_q <= 1'b0;
      end else begin
         cur_q <= bit_i;
         dly_q <= cur_q;
      end
   end

   // one flop per weighted segment; cur_q becomes the delayed tap at this edge
   for (genvar i = 0; i < SEG_N; i++) begin : g_seg
      always_ff @(posedge clk_i) begin
         if (rst_i)          seg_q[i] <= DRV_DOWN;
         else if (coef_i[i]) seg_q[i] <= ~cur_q;
         else                seg_q[i] <= bit_i;
      end
   end

   assign cur_o = cur_q;
   assign dly_o = dly_q;
   assign seg_o = seg_q;

   // R4
   tap_delay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (dly_q == $past(cur_q)));

   // R6
   zero_coef_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (coef_i == '0) |=> (seg_q == {SEG_N{cur_q}}));

   // R5
   full_coef_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (coef_i == '1) |=> (seg_q == {SEG_N{~dly_q}}));

   // R8
   reset_down_chk: assert property (@(posedge clk_i)
      rst_i |=> (seg_q == '0 && !cur_q && !dly_q));

endmodule

// File: rtl/ser_emph_top.sv
module ser_emph_top #(
   parameter int WORD_W = 16,
   parameter int SEG_N  = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [SEG_N-1:0]  coef_i,
   output logic              word_stb_o,
   output logic              ser_o,
   output logic              ser_dly_o,
   output logic [SEG_N-1:0]  seg_up_o
);
   localparam int LVL = ser_emph_pkg::tree_levels(WORD_W);

   if (!ser_emph_pkg::is_pow2(WORD_W)) begin : g_bad_width
      $error("WORD_W must be a power of two of at least 2");
   end
   if (SEG_N < 1 || SEG_N > 8) begin : g_bad_seg
      $error("SEG_N must lie in 1..8");
   end

   logic [LVL-1:0] phase;
   logic           stb;
   logic           tree_bit;

   ser_rate_div #(.WORD_W(WORD_W)) u_div (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .phase_o (phase),
      .stb_o   (stb)
   );

   ser_mux_tree #(.WORD_W(WORD_W)) u_tree (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (stb),
      .word_i  (data_i),
      .phase_i (phase),
      .bit_o   (tree_bit)
   );

   ser_emph_enc #(.SEG_N(SEG_N)) u_enc (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .bit_i  (tree_bit),
      .coef_i (coef_i),
      .cur_o  (ser_o),
      .dly_o  (ser_dly_o),
      .seg_o  (seg_up_o)
   );

   assign word_stb_o = stb;

   // R2
   ser_follows_tree_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (ser_o == $past(tree_bit)));

endmodule

// File: tb/ser_emph_top_tb.sv
module ser_emph_top_tb;
   localparam int W = 16;
   localparam int S = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] data;
   logic [S-1:0] coef;
   logic         stb, ser, ser_dly;
   logic [S-1:0] seg;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // reference state
   int           m_cnt;
   logic [W-1:0] m_held;
   logic         m_cur, m_dly;
   logic [S-1:0] m_seg;

   always #2.5 clk = ~clk;

   ser_emph_top #(.WORD_W(W), .SEG_N(S)) u_dut (
      .clk_i(clk), .rst_i(rst), .data_i(data), .coef_i(coef),
      .word_stb_o(stb), .ser_o(ser), .ser_dly_o(ser_dly), .seg_up_o(seg)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference step for one rising edge, from the requirements
   function automatic void model_edge();
      logic         b;
      logic [S-1:0] s;
      if (rst) begin
         m_cnt = 0; m_held = '0; m_cur = 1'b0; m_dly = 1'b0; m_seg = '0;
      end else begin
         b = m_held[m_cnt];                       // R2: LSB first
         for (int i = 0; i < S; i++) s[i] = coef[i] ? ~m_cur : b;  // R5/R7
         m_seg = s;
         m_dly = m_cur;
         m_cur = b;
         if (m_cnt == W - 1) m_held = data;       // R1 capture
         m_cnt = (m_cnt + 1) % W;
      end
   endfunction

   // called on a falling edge with inputs already set
   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(stb == (m_cnt == W - 1), "R1 word_stb", stb, (m_cnt == W - 1));
      chk(ser == m_cur, {tag, " R2 ser"}, ser, m_cur);
      chk(ser_dly == m_dly, "R4 ser_dly", ser_dly, m_dly);
      chk(seg == m_seg, {tag, " R5 seg"}, seg, m_seg);
      if (coef == '0 && !rst) chk(seg == {S{ser}}, "R6 zero coef", seg, {S{ser}});
      if (rst) chk(seg == '0 && !ser && !stb, "R8 reset", seg, 0);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_2004));
      rst  = 1'b1;
      coef = '1;
      data = 16'hffff;
      m_cnt = 0; m_held = '0; m_cur = 0; m_dly = 0; m_seg = '0;
      @(negedge clk);
      // R8: reset with full coefficient still pulls every segment down
      for (int k = 0; k < 3; k++) step("R8");
      rst = 1'b0;

      // R1 R2 R5: random word every cycle, random coefficient per word
      for (int f = 0; f < 8; f++) begin
         coef = S'($urandom);
         for (int k = 0; k < W; k++) begin
            data = W'($urandom);   // R3: off-strobe values must not leak
            step("R3");
         end
      end

      // R6: zero coefficient, alternating pattern
      coef = '0;
      for (int k = 0; k < 2 * W; k++) begin
         data = 16'haaaa;
         step("R6");
      end

      // R5: all segments on the inverted delayed tap, runs of ones and zeros
      coef = '1;
      for (int k = 0; k < 2 * W; k++) begin
         data = 16'h00ff;
         step("R5");
      end

      // R7: coefficient changing every cycle inside a word
      for (int k = 0; k < 3 * W; k++) begin
         coef = S'($urandom);
         data = W'($urandom);
         step("R7");
      end

      // R8: reset in the middle of a word, then resume
      coef = 4'b1010;
      for (int k = 0; k < 5; k++) step("R8 pre");
      rst = 1'b1;
      for (int k = 0; k < 2; k++) step("R8");
      rst = 1'b0;
      for (int k = 0; k < 2 * W; k++) begin
         data = W'($urandom);
         step("R8 post");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule